// File: doc/BRIEF.md
# Status-Driven Bus Command Decoder

This block sits next to a processor that reports each bus cycle only as a three-bit status code. The block follows that code and finds where each cycle begins and ends. It turns the cycle type into one of five active-low command strobes: memory read, memory write, I/O read, I/O write and interrupt acknowledge. A halt cycle produces a one-clock indication instead of a strobe. A busy flag covers the whole cycle.

No start strobe exists. The all-ones status code means "no cycle". A cycle opens when the status leaves that code. The cycle type is captured at that moment, because the status is valid only early in the cycle. The cycle closes when the status is back at all-ones on a clock where READY is high. Status lines that float high during a bus grant therefore read as idle and cause nothing.

Top module: `bus_cmd_decoder`

## Requirements
- R1: After reset, all five strobes are high, `halt_seen` is 0 and `cyc_busy` is 0.
- R2: While idle, the first clock edge that samples a status other than 111 raises `cyc_busy` at that edge. The decoded strobe goes low on the following edge. A new cycle may start on the clock right after a close.
- R3: The status codes map to strobes as follows: 000 gives `int_ack_n`, 001 gives `io_rd_n`, 010 gives `io_wr_n`, 101 gives `mem_rd_n` and 110 gives `mem_wr_n`.
- R4: Code 100 (instruction fetch) drives `mem_rd_n` low, the same as code 101.
- R5: Code 011 (halt) raises `halt_seen` for exactly one clock, on the edge where a strobe would otherwise assert. No strobe goes low.
- R6: The code sampled at the start edge selects the strobe. Any other non-111 status seen later in the same cycle does not change which strobe is low.
- R7: An edge that samples status 111 with READY high ends the cycle. At that edge the strobe returns high and `cyc_busy` falls.
- R8: While the status is 111 but READY is low, the cycle stays open, `cyc_busy` stays 1 and the active strobe stays low.
- R9: A status held at 111 while idle (including lines floating high) produces no strobe, no halt indication and no busy flag.
- R10: At most one strobe is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_stat | input | 3 | Cycle status code from the processor (111 = passive) |
| ready | input | 1 | Cycle may end when high |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| int_ack_n | output | 1 | Interrupt acknowledge command, active low |
| halt_seen | output | 1 | One-clock pulse for a halt cycle |
| cyc_busy | output | 1 | High from cycle start until cycle end |

## Verification
Two events can share one clock edge: one cycle closing and the idle state that allows the next start. The bench provokes this with back-to-back cycles. Between them the status sits at 111 for exactly one clock, and the next code follows at once. The check is that `cyc_busy` rises again on the very next edge and the new strobe goes low one edge after that. The bench also overlaps a passive status with a low READY and checks that the close waits for READY, with the strobe still held.

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_stat,
  input  logic       ready,
  output logic       mem_rd_n,
  output logic       mem_wr_n,
  output logic       io_rd_n,
  output logic       io_wr_n,
  output logic       int_ack_n,
  output logic       halt_seen,
  output logic       cyc_busy
);

  localparam logic [2:0] C_INTA  = 3'b000;
  localparam logic [2:0] C_IORD  = 3'b001;
  localparam logic [2:0] C_IOWR  = 3'b010;
  localparam logic [2:0] C_HALT  = 3'b011;
  localparam logic [2:0] C_FETCH = 3'b100;
  localparam logic [2:0] C_MRD   = 3'b101;
  localparam logic [2:0] C_MWR   = 3'b110;
  localparam logic [2:0] C_IDLE  = 3'b111;

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_RUN} st_t;

  st_t        st;
  logic [2:0] code_q;
  logic [4:0] cmd_n_q;   // {mrd, mwr, iord, iowr, inta}
  logic [4:0] cmd_sel;
  logic       halt_q;

  wire passive = (bus_stat == C_IDLE);

  always_comb begin
    cmd_sel = 5'b00000;
    case (code_q)
      C_INTA:          cmd_sel = 5'b00001;
      C_IOWR:          cmd_sel = 5'b00010;
      C_IORD:          cmd_sel = 5'b00100;
      C_MWR:           cmd_sel = 5'b01000;
      C_MRD, C_FETCH:  cmd_sel = 5'b10000;
      default:         cmd_sel = 5'b00000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      code_q  <= C_IDLE;
      cmd_n_q <= 5'b11111;
      halt_q  <= 1'b0;
    end else begin
      halt_q <= 1'b0;
      case (st)
        S_IDLE: if (!passive) begin
          st     <= S_ARM;
          code_q <= bus_stat;
        end
        S_ARM: begin
          st      <= S_RUN;
          cmd_n_q <= ~cmd_sel;
          halt_q  <= (code_q == C_HALT);
        end
        S_RUN: if (passive && ready) begin
          st      <= S_IDLE;
          cmd_n_q <= 5'b11111;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, int_ack_n} = cmd_n_q;
  assign halt_seen = halt_q;
  assign cyc_busy  = (st != S_IDLE);

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cmd_n_q) <= 1);

  // R5
  halt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_seen |=> !halt_seen);

  // R5
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_seen |-> (cmd_n_q == 5'b11111));

  // R7
  close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_busy && !halt_seen && passive && ready && $past(cyc_busy)) |=>
      (!cyc_busy && cmd_n_q == 5'b11111));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n_q != 5'b11111 && !ready) |=> $stable(cmd_n_q));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_busy && passive) |=> (!cyc_busy && cmd_n_q == 5'b11111 && !halt_seen));

endmodule

// File: tb/bus_cmd_decoder_test.sv
`timescale 1ns/1ps
module bus_cmd_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_stat = 3'b111;
  logic ready = 1'b1;
  logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, int_ack_n, halt_seen, cyc_busy;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .bus_stat(bus_stat), .ready(ready),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
    .io_wr_n(io_wr_n), .int_ack_n(int_ack_n), .halt_seen(halt_seen),
    .cyc_busy(cyc_busy));

  wire [6:0] got = {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, int_ack_n, halt_seen, cyc_busy};

  function automatic logic [6:0] expv(logic [2:0] code, bit on, bit h, bit busy);
    logic [4:0] s;
    s = 5'b11111;
    if (on) begin
      case (code)
        3'b000: s = 5'b11110;
        3'b001: s = 5'b11011;
        3'b010: s = 5'b11101;
        3'b100, 3'b101: s = 5'b01111;
        3'b110: s = 5'b10111;
        default: s = 5'b11111;
      endcase
    end
    return {s, h, busy};
  endfunction

  function automatic string tag_of(logic [2:0] code);
    if (code == 3'b100) return "R4";
    if (code == 3'b011) return "R5";
    return "R3";
  endfunction

  task automatic check(string rq, logic [6:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", rq, got, exp);
    end
    n_run++;
    if ($countones(~got[6:2]) > 1) begin
      n_fail++;
      $display("FAIL R10: strobes %b expected at most one low", got[6:2]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_cycle(logic [2:0] code, int waits, int lag, bit scramble);
    string t;
    t = tag_of(code);
    bus_stat = code; ready = 1'b1;
    step(); check("R2 start", expv(code, 0, 0, 1));
    if (scramble) bus_stat = 3'($urandom % 7);
    step(); check(t, expv(code, 1, code == 3'b011, 1));
    for (int i = 0; i < waits; i++) begin
      if (scramble) bus_stat = 3'($urandom % 7);
      step(); check(scramble ? "R6" : t, expv(code, 1, 0, 1));
    end
    bus_stat = 3'b111; ready = 1'b0;
    for (int i = 0; i < lag; i++) begin
      step(); check("R8", expv(code, 1, 0, 1));
    end
    ready = 1'b1;
    step(); check("R7", expv(code, 0, 0, 0));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    bus_stat = 3'($urandom % 7);
    step(); step();
    check("R1", expv(3'b111, 0, 0, 0));
    rst_n = 1'b1;
    bus_stat = 3'b111;
    for (int i = 0; i < 4; i++) begin
      step(); check("R9", expv(3'b111, 0, 0, 0));
    end
    for (int c = 0; c < 7; c++) run_cycle(3'(c), 0, 0, 0);
    for (int c = 0; c < 7; c++) run_cycle(3'(c), 3, 2, 0);
    for (int c = 0; c < 7; c++) run_cycle(3'(c), 2, 1, 1);
    step(); check("R9", expv(3'b111, 0, 0, 0));
    for (int i = 0; i < 300; i++) begin
      run_cycle(3'($urandom % 7), int'($urandom % 4), int'($urandom % 3), bit'($urandom % 2));
      if ($urandom % 2) begin
        step(); check("R9", expv(3'b111, 0, 0, 0));
      end
    end
    rst_n = 1'b0; bus_stat = 3'b101;
    step(); check("R1", expv(3'b111, 0, 0, 0));
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule